// File: doc/BRIEF.md
# Single-Error-Correcting Word Memory

This block is a small synchronous single-port storage array. Every 11-bit data word is stored together with 4 check bits as one 15-bit code word. When a word is written, the check bits are generated from the data. When a word is read, the decoder uses the check bits to find and repair any single flipped bit before the data leaves the block, and it reports what happened on status outputs.

Code-word positions are numbered 1 to 15. The check bits occupy the power-of-two positions 1, 2, 4 and 8. Data bit 0 through data bit 10 fill the other positions in ascending order: 3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15. The check bits are the XOR of the 4-bit indices of every data position that holds a 1.

On read, the syndrome is the XOR of the indices of every set position of the fetched word. This is the same as recomputing the check bits and comparing them with the stored ones. A zero syndrome means the word is clean. A nonzero syndrome names the position of the flipped bit, and the decoder inverts that bit.

A test input XORs a 15-bit fault mask into the code word as it is written, so the bench can plant faults at chosen positions.

Top module: `hamm_word_mem`

## Requirements
- R1: A word written with a zero fault mask reads back unchanged, with `fix_flag` low, `lost_flag` low and `err_where` equal to 0.
- R2: Read results appear one clock after the edge that samples `rd_en` high. They are `rd_data`, `fix_flag`, `lost_flag` and `err_where`. `rd_valid` is high for exactly that one cycle and is low in a cycle that follows an edge where `rd_en` was low.
- R3: A single fault planted at a data position p (fault mask bit p-1) is corrected. `rd_data` equals the written data, `fix_flag` is high and `err_where` equals p.
- R4: A single fault planted at a check position (1, 2, 4 or 8) leaves `rd_data` equal to the written data. `fix_flag` is still high and `err_where` equals that position.
- R5: Two faults at positions a and b give `err_where` = a XOR b and `fix_flag` high. The bit at position a XOR b is inverted. The resulting data therefore differs from the written data in every data bit that sits at position a, b or a XOR b. Data bit i sits at the i-th entry of the ascending list 3, 5, 6, 7, 9 to 15. `lost_flag` never rises, because every nonzero syndrome names a position.
- R6: Synchronous active-high reset clears `rd_data`, `rd_valid`, `fix_flag`, `lost_flag` and `err_where` to zero. It leaves the stored words intact.
- R7: While `rd_en` is low, all read outputs hold their last values, whatever the address, the write inputs and the fault mask do.
- R8: A read and a write to the same address at the same edge return the contents from before that write.
- R9: The fault mask has an effect only on an edge where `wr_en` is high. A nonzero mask applied during a read alone leaves the result clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store `wr_data` at `addr` |
| rd_en | input | 1 | Fetch and correct the word at `addr` |
| addr | input | $clog2(DEPTH) | Word address shared by read and write |
| wr_data | input | 11 | Data word to store |
| fault_mask | input | 15 | Test mask XORed into the code word on write; bit p-1 is position p |
| rd_data | output | 11 | Corrected data word |
| rd_valid | output | 1 | One-cycle pulse marking new read results |
| fix_flag | output | 1 | A nonzero syndrome was found and a bit was inverted |
| lost_flag | output | 1 | Uncorrectable outcome; never raised by this code |
| err_where | output | 4 | Syndrome, meaning the position of the repaired bit, or 0 |

## Verification
All read results, including the data, the flags, the syndrome and the valid pulse, are due one clock after the edge that samples `rd_en`. The bench changes inputs on falling edges, lets one rising edge pass, and samples on the next falling edge. Writes take effect at their edge, so a read issued in the following cycle already sees the new word, and a read issued in the same cycle sees the old one. Hold behaviour and the end of the valid pulse are sampled on further falling edges, where no read has been issued.

// File: rtl/hamm_pkg.sv
package hamm_pkg;

    localparam int DATA_W = 11;
    localparam int CHK_W  = 4;
    localparam int CODE_W = DATA_W + CHK_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        OUT_CLEAN = 2'd0,
        OUT_FIXED = 2'd1,
        OUT_LOST  = 2'd2
    } outcome_t;

    typedef struct packed {
        data_t    data;
        outcome_t outcome;
        syn_t     where;
    } rd_result_t;

    // Position p (1-based) is a check slot when it is a power of two.
    function automatic bit is_check_pos(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Position of data bit i: the i-th non-power-of-two position, ascending.
    function automatic int data_slot(int i);
        int n;
        n = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                if (n == i) return p;
                n++;
            end
        end
        return 0;
    endfunction

    // XOR of the indices of all set positions.
    function automatic syn_t syndrome(code_t c);
        syn_t s;
        s = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (c[p-1]) s ^= syn_t'(p);
        end
        return s;
    endfunction

    function automatic code_t scatter(data_t d);
        code_t c;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c[data_slot(i)-1] = d[i];
        end
        return c;
    endfunction

    function automatic data_t gather(code_t c);
        data_t d;
        for (int i = 0; i < DATA_W; i++) begin
            d[i] = c[data_slot(i)-1];
        end
        return d;
    endfunction

    // Check bit k sits at position 2**k and takes bit k of the data syndrome.
    function automatic code_t encode(data_t d);
        code_t c;
        syn_t  s;
        c = scatter(d);
        s = syndrome(c);
        for (int k = 0; k < CHK_W; k++) begin
            c[(1 << k) - 1] = s[k];
        end
        return c;
    endfunction

endpackage

// File: rtl/hamm_encoder.sv
module hamm_encoder
    import hamm_pkg::*;
(
    input  data_t data_in,
    input  code_t fault,
    output code_t code_out
);

    code_t clean;

    always_comb begin
        clean    = encode(data_in);
        code_out = clean ^ fault;
    end

    // R1: a freshly generated code word carries a zero syndrome
    always_comb begin
        if (!$isunknown(data_in)) begin
            assert_clean_word_R1: assert (syndrome(clean) == '0);
        end
    end

endmodule

// File: rtl/hamm_decoder.sv
module hamm_decoder
    import hamm_pkg::*;
(
    input  code_t      code_in,
    output rd_result_t result
);

    syn_t  syn;
    code_t flip;
    code_t repaired;

    always_comb begin
        syn = syndrome(code_in);
        if (syn != '0) begin
            flip = code_t'(1) << (syn - syn_t'(1));
        end else begin
            flip = '0;
        end
        repaired       = code_in ^ flip;
        result.data    = gather(repaired);
        result.where   = syn;
        result.outcome = (syn != '0) ? OUT_FIXED : OUT_CLEAN;
    end

    // R3: after the repair, the word must decode as clean
    always_comb begin
        if (!$isunknown(code_in)) begin
            assert_repair_clean_R3: assert (syndrome(repaired) == '0);
        end
    end

    // R1: a clean fetched word passes through untouched
    always_comb begin
        if (!$isunknown(code_in) && syn == '0) begin
            assert_clean_pass_R1: assert (result.data == gather(code_in));
        end
    end

endmodule

// File: rtl/hamm_store.sv
module hamm_store
    import hamm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  code_t         wr_code,
    output code_t         rd_code
);

    code_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[addr] <= wr_code;
    end

    assign rd_code = cells[addr];

endmodule

// File: rtl/hamm_word_mem.sv
module hamm_word_mem
    import hamm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CODE_W-1:0] fault_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fix_flag,
    output logic              lost_flag,
    output logic [CHK_W-1:0]  err_where
);

    code_t      enc_code;
    code_t      fetched;
    rd_result_t dec;

    hamm_encoder u_enc (
        .data_in  (wr_data),
        .fault    (fault_mask),
        .code_out (enc_code)
    );

    hamm_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_code (enc_code),
        .rd_code (fetched)
    );

    hamm_decoder u_dec (
        .code_in (fetched),
        .result  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            fix_flag  <= 1'b0;
            lost_flag <= 1'b0;
            err_where <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data   <= dec.data;
                fix_flag  <= (dec.outcome == OUT_FIXED);
                lost_flag <= (dec.outcome == OUT_LOST);
                err_where <= dec.where;
            end
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    assert_hold_data_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data) && $stable(err_where) && $stable(fix_flag));

    assert_fix_has_pos_R3: assert property (@(posedge clk) disable iff (rst)
        fix_flag |-> err_where != '0);

    assert_clean_no_pos_R1: assert property (@(posedge clk) disable iff (rst)
        !fix_flag |-> err_where == '0);

    assert_never_lost_R5: assert property (@(posedge clk) disable iff (rst)
        !lost_flag);

endmodule

// File: tb/tb_hamm_word_mem.sv
module tb_hamm_word_mem;

    localparam int DEPTH = 16;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [10:0] wr_data = '0;
    logic [14:0] fault_mask = '0;
    logic [10:0] rd_data;
    logic        rd_valid;
    logic        fix_flag;
    logic        lost_flag;
    logic [3:0]  err_where;

    int checks = 0;
    int errors = 0;

    int slot [11] = '{3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15};

    always #10 clk = ~clk;

    hamm_word_mem #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .fault_mask(fault_mask), .rd_data(rd_data),
        .rd_valid(rd_valid), .fix_flag(fix_flag), .lost_flag(lost_flag),
        .err_where(err_where)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, release them at the next.
    task automatic cycle(input bit w, input bit r, input int a, input int d, input int m);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = AW'(a); wr_data = 11'(d); fault_mask = 15'(m);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; fault_mask = '0;
    endtask

    function automatic int pos_of_mask(int m);
        int s = 0;
        for (int p = 1; p <= 15; p++) if (m[p-1]) s ^= p;
        return s;
    endfunction

    function automatic int data_bit_at(int p);
        for (int i = 0; i < 11; i++) if (slot[i] == p) return i;
        return -1;
    endfunction

    // Expected data after planting mask m on d and inverting the syndrome position.
    function automatic int expect_data(int d, int m);
        int r = d;
        int s = pos_of_mask(m);
        for (int p = 1; p <= 15; p++) begin
            if (m[p-1] && data_bit_at(p) >= 0) r ^= (1 << data_bit_at(p));
        end
        if (s != 0 && data_bit_at(s) >= 0) r ^= (1 << data_bit_at(s));
        return r & 11'h7FF;
    endfunction

    task automatic read_expect(input string tag, input int a, input int d, input int m);
        int ep;
        cycle(1'b0, 1'b1, a, 0, 0);
        ep = pos_of_mask(m);
        check(rd_valid == 1'b1, {tag, " valid"}, rd_valid, 1);
        check(rd_data == 11'(expect_data(d, m)), {tag, " data"}, rd_data, expect_data(d, m));
        check(err_where == 4'(ep), {tag, " where"}, err_where, ep);
        check(fix_flag == (ep != 0), {tag, " fix"}, fix_flag, ep != 0);
        check(lost_flag == 1'b0, {tag, " lost R5"}, lost_flag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int last;
        repeat (3) @(negedge clk);
        // R6: reset state
        check(rd_data == 0 && rd_valid == 0 && fix_flag == 0 && lost_flag == 0 && err_where == 0,
              "R6 reset outputs", {rd_data, rd_valid, fix_flag, lost_flag, err_where}, 0);
        rst = 1'b0;

        // R1: every data value round trips clean
        for (int v = 0; v < 2048; v++) begin
            cycle(1'b1, 1'b0, v % DEPTH, v, 0);
            read_expect("R1 sweep", v % DEPTH, v, 0);
        end

        // R2: valid pulse ends, R7: outputs hold while idle
        last = rd_data;
        cycle(1'b1, 1'b0, 3, 11'h555, 15'h7FFF);
        check(rd_valid == 1'b0, "R2 pulse end", rd_valid, 0);
        check(rd_data == 11'(last), "R7 hold data", rd_data, last);
        check(err_where == 0 && fix_flag == 0, "R7 hold flags", err_where, 0);

        // R3 and R4: every single-fault position over several data values
        for (int p = 1; p <= 15; p++) begin
            for (int k = 0; k < 6; k++) begin
                int d = (p * 151 + k * 389) & 11'h7FF;
                cycle(1'b1, 1'b0, (p + k) % DEPTH, d, 1 << (p - 1));
                if ((p & (p - 1)) == 0)
                    read_expect("R4 check-pos fault", (p + k) % DEPTH, d, 1 << (p - 1));
                else
                    read_expect("R3 data-pos fault", (p + k) % DEPTH, d, 1 << (p - 1));
            end
        end

        // R5: every pair of faults is miscorrected at position a^b
        for (int a = 1; a <= 15; a++) begin
            for (int b = a + 1; b <= 15; b++) begin
                int d = (a * 73 + b * 29) & 11'h7FF;
                int m = (1 << (a - 1)) | (1 << (b - 1));
                cycle(1'b1, 1'b0, a, d, m);
                read_expect("R5 double fault", a, d, m);
            end
        end

        // R8: read and write same address at one edge see old contents
        cycle(1'b1, 1'b0, 9, 11'h123, 0);
        cycle(1'b1, 1'b1, 9, 11'h6DB, 0);
        check(rd_data == 11'h123, "R8 read-before-write", rd_data, 11'h123);
        read_expect("R8 new contents", 9, 11'h6DB, 0);

        // R9: fault mask without write has no effect
        cycle(1'b1, 1'b0, 4, 11'h0F0, 0);
        cycle(1'b0, 1'b1, 4, 0, 15'h0041);
        check(rd_data == 11'h0F0 && err_where == 0 && fix_flag == 0, "R9 mask ignored on read",
              {rd_data, err_where}, {11'h0F0, 4'h0});

        // R6: reset clears outputs but keeps contents
        cycle(1'b1, 1'b0, 12, 11'h3A5, 15'h0100);
        read_expect("R6 pre-reset", 12, 11'h3A5, 15'h0100);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(rd_data == 0 && err_where == 0 && fix_flag == 0 && rd_valid == 0,
              "R6 reset clears", {rd_data, err_where}, 0);
        read_expect("R6 contents kept", 12, 11'h3A5, 15'h0100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule